// File: doc/BRIEF.md
# Multidrop Serial Receiver with Node Address Filter

This block receives asynchronous serial frames on one line and puts each byte in a one-entry holding buffer. A frame is a start bit, eight data bits sent low bit first, an optional ninth bit and a stop bit. Each bit is sampled at its midpoint. A tick input marks the sampling instants, and `OVS` ticks make up one bit period.

On a shared bus many nodes listen to the same line. When multiprocessor filtering is on, the block treats frames that carry an address marker as address frames. It compares each one against two patterns: a per-node given address, formed from an address byte and a don't-care mask, and a broadcast pattern derived from the same two bytes. Only frames meant for this node raise the receive-complete flag. Software reads the buffer and then clears the flag with a one-cycle pulse. Baud generation, transmission and the synchronous shift mode sit outside the block. When mode 0 is selected, the receiver stays idle.

Top module: `uart_addr_rx`

## Requirements
- R1: `mode_sel` encoding: 0 is synchronous (ignored), 1 is 8-bit frames, 2 and 3 are 9-bit frames. Data is received low bit first into `rx_data`. `rx_bit9` holds the ninth bit in 9-bit modes and the stop bit in mode 1.
- R2: A low level on the line at a tick starts a frame. If the line is high again at the start bit's midpoint (`OVS/2` ticks later), the receiver returns to idle and produces no frame. A later valid frame is received normally.
- R3: With `mp_en` low, every completed frame in modes 1 to 3 loads the buffer and sets `rx_done`, even when its stop bit is low.
- R4: After reset `rx_done` is 0 and `rx_data` is 0. `rx_done` stays at 1 until `flag_clr` is pulsed. While it is 1, a newly completed frame does not change `rx_data` or `rx_bit9`.
- R5: In modes 2 and 3 with `mp_en` high, a frame whose ninth bit is 0 never sets `rx_done`.
- R6: With filtering on, a frame matches the given address when `(byte ^ node_addr) & addr_mask` is zero. A mask bit of 0 is don't-care. For example, address 0x56 with mask 0xFC accepts 0x57 and rejects 0x5A.
- R7: With `addr_mask` = 0xFF, only the byte equal to `node_addr` matches the given address.
- R8: The broadcast pattern is `B = node_addr | addr_mask`, and a byte matches it when `byte & B == B`. When B is zero, every byte matches. With address 0x56 and mask 0xFC, 0xFE is accepted.
- R9: In mode 1 with `mp_en` high, `rx_done` is set only when the byte matches and the stop bit is 1.
- R10: In mode 0 no frame is received and `rx_done` never sets, whatever the value of `mp_en`.
- R11: `frame_err` is 0 after reset. It is set by any completed frame whose stop bit samples 0, filtered or not, and it stays set until `flag_clr`.
- R12: If `flag_clr` and an accepted frame fall in the same cycle, the frame is loaded and `rx_done` is 1 afterwards. Setting takes priority over clearing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_line | input | 1 | Serial line, idle high |
| samp_tick | input | 1 | Sampling tick, OVS per bit period |
| mode_sel | input | 2 | Frame mode (0 sync/ignored, 1 8-bit, 2/3 9-bit) |
| mp_en | input | 1 | Multiprocessor address filtering enable |
| node_addr | input | DATA_W | Node address byte |
| addr_mask | input | DATA_W | Address mask, 0 = don't-care |
| flag_clr | input | 1 | One-cycle clear of rx_done and frame_err |
| rx_data | output | DATA_W | Received byte buffer |
| rx_bit9 | output | 1 | Ninth bit, or stop bit in mode 1 |
| rx_done | output | 1 | Receive-complete flag |
| frame_err | output | 1 | Low stop bit seen |

## Verification
A software clear of the flag can land in the same cycle in which a new frame is accepted. In that case the load must take priority, and the buffer must take the new byte even though the flag was set just before. The bench provokes this by holding `flag_clr` high for the whole of a second frame while the flag is still set from a first one. It then watches for `rx_done` rising while the clear is still asserted and checks that the buffer then shows the second byte.

// File: rtl/uart_addr_rx_pkg.sv
package uart_addr_rx_pkg;

   typedef enum logic [2:0] {
      RX_IDLE  = 3'd0,
      RX_START = 3'd1,
      RX_DATA  = 3'd2,
      RX_NINTH = 3'd3,
      RX_STOP  = 3'd4
   } rx_state_e;

   localparam logic [1:0] MODE_SYNC = 2'd0;

   // 9-bit frame modes have the upper mode bit set
   function automatic logic mode_is_nine(input logic [1:0] m);
      return m[1];
   endfunction

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);

   if (STAGES < 0) begin : g_bad_stages
      $error("rx_line_sync: STAGES must be non-negative");
   end

   if (STAGES == 0) begin : g_bypass
      assign dout = din;
   end else begin : g_chain
      logic [STAGES-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q[0] <= 1'b1;
         else        q[0] <= din;
      end
      for (genvar i = 1; i < STAGES; i++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q[i] <= 1'b1;
            else        q[i] <= q[i-1];
         end
      end
      assign dout = q[STAGES-1];
   end

endmodule

// File: rtl/rx_frame_engine.sv
module rx_frame_engine
   import uart_addr_rx_pkg::*;
#(
   parameter int OVS    = 16,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              nine,
   input  logic              line,
   input  logic              tick,
   output logic              done,
   output logic [DATA_W-1:0] data,
   output logic              bit9,
   output logic              stop_ok
);

   localparam int CW   = (OVS > 1) ? $clog2(OVS) : 1;
   localparam int IW   = (DATA_W > 1) ? $clog2(DATA_W) : 1;
   localparam int HALF = OVS / 2;
   localparam logic [CW-1:0] MID_CNT  = CW'(HALF - 1);
   localparam logic [CW-1:0] LAST_CNT = CW'(OVS - 1);
   localparam logic [IW-1:0] LAST_IDX = IW'(DATA_W - 1);

   if (OVS < 2 || (OVS % 2) != 0) begin : g_bad_ovs
      $error("rx_frame_engine: OVS must be even and at least 2");
   end
   if (DATA_W < 2) begin : g_bad_dw
      $error("rx_frame_engine: DATA_W must be at least 2");
   end

   rx_state_e         state;
   logic [CW-1:0]     cnt;
   logic [IW-1:0]     idx;
   logic [DATA_W-1:0] shreg;
   logic              ninth_q;
   logic              at_mid;

   assign at_mid = (cnt == LAST_CNT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= RX_IDLE;
         cnt     <= '0;
         idx     <= '0;
         shreg   <= '0;
         ninth_q <= 1'b0;
         done    <= 1'b0;
         data    <= '0;
         bit9    <= 1'b0;
         stop_ok <= 1'b1;
      end else begin
         done <= 1'b0;
         if (!en) begin
            state <= RX_IDLE;
            cnt   <= '0;
         end else if (tick) begin
            unique case (state)
               RX_IDLE: begin
                  if (!line) begin
                     state <= RX_START;
                     cnt   <= '0;
                  end
               end
               RX_START: begin
                  if (cnt == MID_CNT) begin
                     cnt   <= '0;
                     idx   <= '0;
                     state <= line ? RX_IDLE : RX_DATA;
                  end else begin
                     cnt <= cnt + CW'(1);
                  end
               end
               RX_DATA: begin
                  if (at_mid) begin
                     cnt   <= '0;
                     shreg <= {line, shreg[DATA_W-1:1]};
                     idx   <= idx + IW'(1);
                     if (idx == LAST_IDX) state <= nine ? RX_NINTH : RX_STOP;
                  end else begin
                     cnt <= cnt + CW'(1);
                  end
               end
               RX_NINTH: begin
                  if (at_mid) begin
                     cnt     <= '0;
                     ninth_q <= line;
                     state   <= RX_STOP;
                  end else begin
                     cnt <= cnt + CW'(1);
                  end
               end
               RX_STOP: begin
                  if (at_mid) begin
                     cnt     <= '0;
                     done    <= 1'b1;
                     data    <= shreg;
                     stop_ok <= line;
                     bit9    <= nine ? ninth_q : line;
                     state   <= RX_IDLE;
                  end else begin
                     cnt <= cnt + CW'(1);
                  end
               end
               default: state <= RX_IDLE;
            endcase
         end
      end
   end

   // R1
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

endmodule

// File: rtl/rx_addr_match.sv
module rx_addr_match #(
   parameter int DATA_W   = 8,
   parameter bit BCAST_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] rx_byte,
   input  logic [DATA_W-1:0] addr,
   input  logic [DATA_W-1:0] mask,
   output logic              hit
);

   logic given_hit;
   logic bcast_hit;
   logic [DATA_W-1:0] bpat;

   assign given_hit = (((rx_byte ^ addr) & mask) == '0);
   assign bpat      = addr | mask;

   if (BCAST_EN) begin : g_bcast
      assign bcast_hit = ((rx_byte & bpat) == bpat);
   end else begin : g_no_bcast
      assign bcast_hit = 1'b0;
   end

   assign hit = given_hit | bcast_hit;

   // R7
   exact_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mask == '1) |-> (given_hit == (rx_byte == addr)));

   // R8
   bcast_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (BCAST_EN && bpat == '0) |-> hit);

endmodule

// File: rtl/uart_addr_rx.sv
module uart_addr_rx
   import uart_addr_rx_pkg::*;
#(
   parameter int OVS         = 16,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit BCAST_EN    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_line,
   input  logic              samp_tick,
   input  logic [1:0]        mode_sel,
   input  logic              mp_en,
   input  logic [DATA_W-1:0] node_addr,
   input  logic [DATA_W-1:0] addr_mask,
   input  logic              flag_clr,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_bit9,
   output logic              rx_done,
   output logic              frame_err
);

   logic              line_s;
   logic              rx_en;
   logic              nine;
   logic              filt;
   logic              frm_done;
   logic [DATA_W-1:0] frm_data;
   logic              frm_bit9;
   logic              frm_stop;
   logic              addr_hit;
   logic              accept;
   logic              load;

   assign rx_en = (mode_sel != MODE_SYNC);
   assign nine  = mode_is_nine(mode_sel);
   assign filt  = mp_en & rx_en;

   rx_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (rx_line),
      .dout (line_s)
   );

   rx_frame_engine #(.OVS(OVS), .DATA_W(DATA_W)) eng_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (rx_en),
      .nine   (nine),
      .line   (line_s),
      .tick   (samp_tick),
      .done   (frm_done),
      .data   (frm_data),
      .bit9   (frm_bit9),
      .stop_ok(frm_stop)
   );

   rx_addr_match #(.DATA_W(DATA_W), .BCAST_EN(BCAST_EN)) match_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .rx_byte(frm_data),
      .addr   (node_addr),
      .mask   (addr_mask),
      .hit    (addr_hit)
   );

   // frm_bit9 carries the stop bit in 8-bit mode, so one term covers both
   assign accept = frm_done & (~filt | (addr_hit & frm_bit9));
   assign load   = accept & (~rx_done | flag_clr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_data   <= '0;
         rx_bit9   <= 1'b0;
         rx_done   <= 1'b0;
         frame_err <= 1'b0;
      end else begin
         if (load) begin
            rx_data <= frm_data;
            rx_bit9 <= frm_bit9;
         end
         rx_done   <= load | (rx_done & ~flag_clr);
         frame_err <= (frm_done & ~frm_stop) | (frame_err & ~flag_clr);
      end
   end

   // R4
   hold_buf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_done && !flag_clr) |=> (rx_done && $stable(rx_data)));

   // R5
   data_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_done && mode_sel[1] && mp_en && !frm_bit9 && !rx_done) |=> !rx_done);

   // R10
   sync_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_sel == 2'd0) |=> !frm_done);

   // R11
   ferr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_done && !frm_stop) |=> frame_err);

   // R12
   clr_race_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_done && !mp_en && mode_sel != 2'd0 && flag_clr) |=> rx_done);

endmodule

// File: tb/uart_addr_rx_tb_top.sv
`timescale 1ns/1ps
module uart_addr_rx_tb_top;

   localparam int OVS = 4;
   localparam int DW  = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rx_line = 1'b1;
   logic          samp_tick = 1'b0;
   logic [1:0]    mode_sel = 2'd1;
   logic          mp_en = 1'b0;
   logic [DW-1:0] node_addr = '0;
   logic [DW-1:0] addr_mask = '0;
   logic          flag_clr = 1'b0;
   logic [DW-1:0] rx_data;
   logic          rx_bit9;
   logic          rx_done;
   logic          frame_err;

   int total = 0;
   int bad   = 0;

   always #2 clk = ~clk;

   always @(posedge clk) begin
      if (!rst_n) samp_tick <= 1'b0;
      else        samp_tick <= ~samp_tick;
   end

   uart_addr_rx #(.OVS(OVS), .DATA_W(DW)) dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .rx_line  (rx_line),
      .samp_tick(samp_tick),
      .mode_sel (mode_sel),
      .mp_en    (mp_en),
      .node_addr(node_addr),
      .addr_mask(addr_mask),
      .flag_clr (flag_clr),
      .rx_data  (rx_data),
      .rx_bit9  (rx_bit9),
      .rx_done  (rx_done),
      .frame_err(frame_err)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic line_bit(input logic v);
      rx_line = v;
      repeat (2 * OVS) @(negedge clk);
   endtask

   task automatic send_frame(input logic [7:0] b, input logic with9,
                             input logic b9, input logic stopv);
      line_bit(1'b0);
      for (int i = 0; i < 8; i++) line_bit(b[i]);
      if (with9) line_bit(b9);
      line_bit(stopv);
      repeat (3) line_bit(1'b1);
   endtask

   task automatic pulse_clr();
      flag_clr = 1'b1;
      @(negedge clk);
      flag_clr = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_reset();
      chk("R4 reset done", rx_done, 0);
      chk("R4 reset data", rx_data, 0);
      chk("R11 reset ferr", frame_err, 0);
   endtask

   task automatic t_plain8();
      mode_sel = 2'd1; mp_en = 1'b0;
      send_frame(8'hA5, 1'b0, 1'b0, 1'b1);
      chk("R3 done mode1", rx_done, 1);
      chk("R1 data lsb first", rx_data, 32'hA5);
      chk("R1 bit9 is stop", rx_bit9, 1);
      pulse_clr();
      chk("R4 cleared", rx_done, 0);
   endtask

   task automatic t_hold();
      send_frame(8'hA5, 1'b0, 1'b0, 1'b1);
      send_frame(8'h3C, 1'b0, 1'b0, 1'b1);
      chk("R4 held done", rx_done, 1);
      chk("R4 no overwrite", rx_data, 32'hA5);
      pulse_clr();
   endtask

   task automatic t_nine_plain();
      mode_sel = 2'd2; mp_en = 1'b0;
      send_frame(8'h3C, 1'b1, 1'b0, 1'b1);
      chk("R3 done mode2", rx_done, 1);
      chk("R1 data mode2", rx_data, 32'h3C);
      chk("R1 ninth bit", rx_bit9, 0);
      pulse_clr();
   endtask

   task automatic t_filter9();
      mode_sel = 2'd3; mp_en = 1'b1; node_addr = 8'h56; addr_mask = 8'hFC;
      send_frame(8'h56, 1'b1, 1'b0, 1'b1);
      chk("R5 data frame ignored", rx_done, 0);
      send_frame(8'h57, 1'b1, 1'b1, 1'b1);
      chk("R6 masked match", rx_done, 1);
      chk("R6 masked data", rx_data, 32'h57);
      pulse_clr();
      send_frame(8'h5A, 1'b1, 1'b1, 1'b1);
      chk("R6 masked miss", rx_done, 0);
      send_frame(8'hFE, 1'b1, 1'b1, 1'b1);
      chk("R8 broadcast hit", rx_done, 1);
      chk("R8 broadcast data", rx_data, 32'hFE);
      pulse_clr();
   endtask

   task automatic t_exact();
      mode_sel = 2'd2; mp_en = 1'b1; node_addr = 8'hF1; addr_mask = 8'hFF;
      send_frame(8'hF1, 1'b1, 1'b1, 1'b1);
      chk("R7 exact hit", rx_done, 1);
      pulse_clr();
      send_frame(8'hF3, 1'b1, 1'b1, 1'b1);
      chk("R7 exact miss", rx_done, 0);
   endtask

   task automatic t_bcast_zero();
      mode_sel = 2'd2; mp_en = 1'b1; node_addr = 8'h00; addr_mask = 8'h00;
      send_frame(8'h9E, 1'b1, 1'b1, 1'b1);
      chk("R8 all dont care", rx_done, 1);
      pulse_clr();
   endtask

   task automatic t_filter8();
      mode_sel = 2'd1; mp_en = 1'b1; node_addr = 8'h56; addr_mask = 8'hFF;
      send_frame(8'h56, 1'b0, 1'b0, 1'b1);
      chk("R9 match good stop", rx_done, 1);
      pulse_clr();
      send_frame(8'h56, 1'b0, 1'b0, 1'b0);
      chk("R9 match bad stop", rx_done, 0);
      chk("R11 ferr filtered", frame_err, 1);
      pulse_clr();
      chk("R11 ferr cleared", frame_err, 0);
      send_frame(8'h55, 1'b0, 1'b0, 1'b1);
      chk("R9 mismatch", rx_done, 0);
   endtask

   task automatic t_mode0();
      mode_sel = 2'd0; mp_en = 1'b1; node_addr = 8'h56; addr_mask = 8'hFF;
      send_frame(8'h56, 1'b0, 1'b0, 1'b1);
      chk("R10 mode0 no done", rx_done, 0);
      mp_en = 1'b0;
      send_frame(8'h77, 1'b0, 1'b0, 1'b0);
      chk("R10 mode0 plain no done", rx_done, 0);
      chk("R10 mode0 no ferr", frame_err, 0);
   endtask

   task automatic t_glitch();
      mode_sel = 2'd1; mp_en = 1'b0;
      rx_line = 1'b0;
      repeat (2) @(negedge clk);
      rx_line = 1'b1;
      repeat (4) line_bit(1'b1);
      chk("R2 glitch rejected", rx_done, 0);
      send_frame(8'h81, 1'b0, 1'b0, 1'b1);
      chk("R2 recovery done", rx_done, 1);
      chk("R2 recovery data", rx_data, 32'h81);
      pulse_clr();
   endtask

   task automatic t_ferr_plain();
      mode_sel = 2'd1; mp_en = 1'b0;
      send_frame(8'h42, 1'b0, 1'b0, 1'b0);
      chk("R3 done despite bad stop", rx_done, 1);
      chk("R11 ferr set", frame_err, 1);
      chk("R3 data bad stop", rx_data, 32'h42);
      pulse_clr();
   endtask

   task automatic t_race();
      logic seen = 1'b0;
      logic [7:0] cap = '0;
      mode_sel = 2'd1; mp_en = 1'b0;
      send_frame(8'h11, 1'b0, 1'b0, 1'b1);
      chk("R12 first frame", rx_done, 1);
      flag_clr = 1'b1;
      @(negedge clk);
      fork
         send_frame(8'h22, 1'b0, 1'b0, 1'b1);
         begin
            repeat (14 * 2 * OVS) begin
               @(negedge clk);
               if (rx_done && !seen) begin
                  seen = 1'b1;
                  cap  = rx_data;
               end
            end
         end
      join
      flag_clr = 1'b0;
      @(negedge clk);
      chk("R12 set wins over clear", seen, 1);
      chk("R12 new byte loaded", cap, 32'h22);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      t_plain8();
      t_hold();
      t_nine_plain();
      t_filter9();
      t_exact();
      t_bcast_zero();
      t_filter8();
      t_mode0();
      t_glitch();
      t_ferr_plain();
      t_race();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule